// File: doc/BRIEF.md
# MSI-X Vector Mask and Pending Controller

This block handles message-interrupt delivery for a function with a fixed number of interrupt vectors. It keeps the message-control enable and function-mask bits. For each vector it keeps one mask bit and one pending bit. Each interrupt request on a vector is turned into one message request on a valid/ready output, or it is recorded as pending when the vector is masked. A pending vector is delivered later, once its mask is lifted.

Software writes reach the block through two ports:

- a byte write to the upper half of the message-control word;
- a per-vector mask write, which carries bit 0 of the vector-control word.

A control-byte write made while the function is enabled does two things. It sends a one-cycle strobe that tells the legacy wired-interrupt logic to drop its line. If the function mask is clear, it also starts a sweep that walks every vector in ascending order, one per cycle, and hands each pending, unmasked vector to the message output.

Messages wait in a per-vector "owed" set. An output stage drains that set, lowest index first, holding one message at a time until the consumer accepts it.

Top module: `msixc_top`

## Requirements
- R1: After reset, the enable and function-mask bits are 0. Every vector's mask bit is 1, no vector is pending, no message is offered and the sweep is idle.
- R2: `ctl_word` reads as follows:
  - bit 15 is enable;
  - bit 14 is function mask;
  - bits 10:0 hold NUM_VEC-1;
  - all other bits are 0.
  A control-byte write stores only its bits 7 (enable) and 6 (function mask). Its other bits have no effect.
- R3: A vector-mask write stores `vc_wr_mask` as that vector's mask bit, which is visible on `vec_mask`. A vector is masked when the function mask is 1 or its own mask bit is 1. The function mask overrides a cleared vector mask.
- R4: While enabled, a request on a masked vector sets its pending bit and produces no message.
- R5: While enabled, a request on an unmasked vector produces exactly one message carrying that vector's index, and its pending bit stays 0.
- R6: While enable is 0, requests set no pending bit and no message is started.
- R7: A vector-mask write that leaves a pending vector unmasked, while enabled with the function mask clear, clears its pending bit and produces one message for it.
- R8: A control-byte write whose new enable bit is 1 raises `intx_deassert` for exactly one cycle, in the cycle after the write. A write with enable 0 raises no strobe.
- R9: A control-byte write with enable 1 and function mask 0 starts a sweep:
  - `sweep_busy` is high for exactly NUM_VEC cycles;
  - every pending, unmasked vector is delivered once and its pending bit is cleared;
  - the resulting messages come out in ascending vector order.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and `msg_idx` hold steady. At most one message is transferred per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_en | input | 1 | Write strobe for the upper message-control byte |
| ctl_wr_data | input | 8 | Byte written; bit 7 enable, bit 6 function mask |
| vc_wr_en | input | 1 | Vector-mask write strobe |
| vc_wr_idx | input | VEC_W | Vector addressed by the mask write |
| vc_wr_mask | input | 1 | New mask bit (vector-control bit 0) |
| req_valid | input | 1 | Interrupt request strobe |
| req_idx | input | VEC_W | Vector being requested |
| msg_valid | output | 1 | A message request is offered |
| msg_idx | output | VEC_W | Vector index of the offered message |
| msg_ready | input | 1 | Consumer accepts the offered message |
| ctl_word | output | 16 | Message-control word readout |
| vec_mask | output | NUM_VEC | Per-vector mask bits |
| vec_pend | output | NUM_VEC | Per-vector pending bits |
| sweep_busy | output | 1 | Sweep in progress |
| intx_deassert | output | 1 | One-cycle strobe to drop the legacy interrupt line |

## Verification
The bench walks every vector through four paths:

- parked while masked;
- released by an individual unmask;
- fired directly while unmasked;
- ignored while disabled.

It targets the cases where the function mask and per-vector masks disagree. A design that let a cleared vector mask beat a set function mask would emit messages during the function-masked window. A design that swept with the wrong ordering or skipped the last vector would misorder the 1, 3, 6 re-delivery, or leave a pending bit set.

Back-pressure with two owed vectors checks that an offered message is not replaced before it is accepted. Writes of the full byte 0xFF check that reserved control bits do not appear on the readout.

// File: rtl/msixc_pkg.sv
package msixc_pkg;

  // Encoded table size: vector count minus one in an 11-bit field.
  function automatic logic [10:0] tbl_code(input int n);
    return 11'(n - 1);
  endfunction

  // A vector is masked by either the function-wide or its own mask.
  function automatic logic eff_masked(input logic fmask, input logic vmask);
    return fmask | vmask;
  endfunction

  // Only bits 7 and 6 of the upper control byte take software writes.
  localparam logic [7:0] CTL_HI_WMASK = 8'hC0;

  function automatic logic [7:0] ctl_merge(input logic [7:0] old_b,
                                           input logic [7:0] wr_b);
    return (wr_b & CTL_HI_WMASK) | (old_b & ~CTL_HI_WMASK);
  endfunction

endpackage

// File: rtl/msixc_ctl.sv
module msixc_ctl
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [7:0]       ctl_wr_data,
  output logic [15:0]      ctl_word,
  output logic             en_q,
  output logic             en_nxt,
  output logic             fm_nxt,
  output logic             intx_deassert,
  output logic             sweep_busy,
  output logic [VEC_W-1:0] sweep_idx
);

  localparam logic [VEC_W-1:0] LAST_VEC = VEC_W'(NUM_VEC - 1);
  localparam logic [15:0]      CTL_RST  = {5'b0, tbl_code(NUM_VEC)};

  logic [15:0]      ctl_q;
  logic [7:0]       hi_nxt;
  logic             sweep_start;
  logic             intx_q;
  logic             busy_q;
  logic [VEC_W-1:0] ptr_q;

  assign hi_nxt      = ctl_wr_en ? ctl_merge(ctl_q[15:8], ctl_wr_data) : ctl_q[15:8];
  assign en_nxt      = hi_nxt[7];
  assign fm_nxt      = hi_nxt[6];
  assign sweep_start = ctl_wr_en && en_nxt && !fm_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      intx_q <= 1'b0;
      busy_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      ctl_q[15:8] <= hi_nxt;
      intx_q      <= ctl_wr_en && en_nxt;
      if (sweep_start) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
      end else if (busy_q) begin
        if (ptr_q == LAST_VEC) begin
          busy_q <= 1'b0;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign ctl_word      = ctl_q;
  assign en_q          = ctl_q[15];
  assign intx_deassert = intx_q;
  assign sweep_busy    = busy_q;
  assign sweep_idx     = ptr_q;

  AST_INTX_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> en_q); // R8

  AST_SWEEP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_busy && !ctl_wr_en && sweep_idx != LAST_VEC) |=>
      (sweep_busy && sweep_idx == $past(sweep_idx) + 1'b1)); // R9

endmodule

// File: rtl/msixc_vec_state.sv
module msixc_vec_state
  import msixc_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_nxt,
  input  logic               fm_nxt,
  input  logic               vc_wr_en,
  input  logic [VEC_W-1:0]   vc_wr_idx,
  input  logic               vc_wr_mask,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_idx,
  input  logic               sweep_step,
  input  logic [VEC_W-1:0]   sweep_idx,
  input  logic               take_en,
  input  logic [VEC_W-1:0]   take_idx,
  output logic [NUM_VEC-1:0] vmask_q,
  output logic [NUM_VEC-1:0] pend_q,
  output logic [NUM_VEC-1:0] due_q
);

  // Named per-vector events, visible to the assertions below.
  logic [NUM_VEC-1:0] unmask_hit;
  logic [NUM_VEC-1:0] sweep_hit;
  logic [NUM_VEC-1:0] req_fire;
  logic [NUM_VEC-1:0] req_park;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    logic wr_sel, vm_nxt, masked_nxt, req_sel, take_sel;

    assign wr_sel     = vc_wr_en && (vc_wr_idx == VEC_W'(i));
    assign vm_nxt     = wr_sel ? vc_wr_mask : vmask_q[i];
    assign masked_nxt = eff_masked(fm_nxt, vm_nxt);
    assign req_sel    = req_valid && (req_idx == VEC_W'(i)) && en_nxt;
    assign take_sel   = take_en && (take_idx == VEC_W'(i));

    assign unmask_hit[i] = wr_sel && en_nxt && !masked_nxt && pend_q[i];
    assign sweep_hit[i]  = sweep_step && (sweep_idx == VEC_W'(i)) &&
                           en_nxt && !masked_nxt && pend_q[i];
    assign req_fire[i]   = req_sel && !masked_nxt;
    assign req_park[i]   = req_sel && masked_nxt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vmask_q[i] <= 1'b1;
        pend_q[i]  <= 1'b0;
        due_q[i]   <= 1'b0;
      end else begin
        vmask_q[i] <= vm_nxt;
        pend_q[i]  <= (pend_q[i] && !(unmask_hit[i] || sweep_hit[i])) || req_park[i];
        due_q[i]   <= en_nxt &&
                      ((due_q[i] && !take_sel) || unmask_hit[i] || sweep_hit[i] || req_fire[i]);
      end
    end

    AST_PEND_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(req_valid && req_idx == VEC_W'(i))); // R4

    AST_PEND_CLR_OWED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[i]) |-> due_q[i]); // R7
  end

endmodule

// File: rtl/msixc_msg_out.sv
module msixc_msg_out #(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_q,
  input  logic [NUM_VEC-1:0] due_q,
  input  logic               msg_ready,
  output logic               take_en,
  output logic [VEC_W-1:0]   take_idx,
  output logic               msg_valid,
  output logic [VEC_W-1:0]   msg_idx
);

  logic             pick_found;
  logic [VEC_W-1:0] pick_idx;
  logic             valid_q;
  logic [VEC_W-1:0] idx_q;

  // Lowest owed vector wins.
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int k = NUM_VEC - 1; k >= 0; k--) begin
      if (due_q[k]) begin
        pick_found = 1'b1;
        pick_idx   = VEC_W'(k);
      end
    end
  end

  assign take_en  = en_q && pick_found && (!valid_q || msg_ready);
  assign take_idx = pick_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (take_en) begin
      valid_q <= 1'b1;
      idx_q   <= pick_idx;
    end else if (msg_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign msg_valid = valid_q;
  assign msg_idx   = idx_q;

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_idx))); // R10

  AST_NO_MSG_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en_q)); // R6

endmodule

// File: rtl/msixc_top.sv
module msixc_top #(
  parameter int NUM_VEC = 8,
  parameter int VEC_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_en,
  input  logic [7:0]         ctl_wr_data,
  input  logic               vc_wr_en,
  input  logic [VEC_W-1:0]   vc_wr_idx,
  input  logic               vc_wr_mask,
  input  logic               req_valid,
  input  logic [VEC_W-1:0]   req_idx,
  output logic               msg_valid,
  output logic [VEC_W-1:0]   msg_idx,
  input  logic               msg_ready,
  output logic [15:0]        ctl_word,
  output logic [NUM_VEC-1:0] vec_mask,
  output logic [NUM_VEC-1:0] vec_pend,
  output logic               sweep_busy,
  output logic               intx_deassert
);

  logic               en_q, en_nxt, fm_nxt;
  logic [VEC_W-1:0]   sweep_idx;
  logic               take_en;
  logic [VEC_W-1:0]   take_idx;
  logic [NUM_VEC-1:0] due_q;

  msixc_ctl #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_wr_en     (ctl_wr_en),
    .ctl_wr_data   (ctl_wr_data),
    .ctl_word      (ctl_word),
    .en_q          (en_q),
    .en_nxt        (en_nxt),
    .fm_nxt        (fm_nxt),
    .intx_deassert (intx_deassert),
    .sweep_busy    (sweep_busy),
    .sweep_idx     (sweep_idx)
  );

  msixc_vec_state #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_nxt     (en_nxt),
    .fm_nxt     (fm_nxt),
    .vc_wr_en   (vc_wr_en),
    .vc_wr_idx  (vc_wr_idx),
    .vc_wr_mask (vc_wr_mask),
    .req_valid  (req_valid),
    .req_idx    (req_idx),
    .sweep_step (sweep_busy),
    .sweep_idx  (sweep_idx),
    .take_en    (take_en),
    .take_idx   (take_idx),
    .vmask_q    (vec_mask),
    .pend_q     (vec_pend),
    .due_q      (due_q)
  );

  msixc_msg_out #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .due_q     (due_q),
    .msg_ready (msg_ready),
    .take_en   (take_en),
    .take_idx  (take_idx),
    .msg_valid (msg_valid),
    .msg_idx   (msg_idx)
  );

endmodule

// File: tb/msixc_top_tb.sv
module msixc_top_tb;
  localparam int NV = 8;
  localparam int VW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctl_wr_en = 1'b0;
  logic [7:0]    ctl_wr_data = '0;
  logic          vc_wr_en = 1'b0;
  logic [VW-1:0] vc_wr_idx = '0;
  logic          vc_wr_mask = 1'b0;
  logic          req_valid = 1'b0;
  logic [VW-1:0] req_idx = '0;
  logic          msg_valid;
  logic [VW-1:0] msg_idx;
  logic          msg_ready = 1'b1;
  logic [15:0]   ctl_word;
  logic [NV-1:0] vec_mask;
  logic [NV-1:0] vec_pend;
  logic          sweep_busy;
  logic          intx_deassert;

  int n_tests = 0;
  int n_fail  = 0;
  int msg_cnt = 0;
  int msg_log [0:63];
  int intx_cnt = 0;
  int busy_cnt = 0;
  bit finished = 0;

  msixc_top #(.NUM_VEC(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .vc_wr_en(vc_wr_en), .vc_wr_idx(vc_wr_idx), .vc_wr_mask(vc_wr_mask),
    .req_valid(req_valid), .req_idx(req_idx), .msg_valid(msg_valid),
    .msg_idx(msg_idx), .msg_ready(msg_ready), .ctl_word(ctl_word),
    .vec_mask(vec_mask), .vec_pend(vec_pend), .sweep_busy(sweep_busy),
    .intx_deassert(intx_deassert)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (msg_valid && msg_ready) begin
        if (msg_cnt < 64) msg_log[msg_cnt] = int'(msg_idx);
        msg_cnt++;
      end
      if (intx_deassert) intx_cnt++;
      if (sweep_busy) busy_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  task automatic ctl_wr(input logic [7:0] b);
    @(posedge clk); #1;
    ctl_wr_en = 1'b1; ctl_wr_data = b;
    @(posedge clk); #1;
    ctl_wr_en = 1'b0;
  endtask

  task automatic vc_wr(input int v, input logic m);
    @(posedge clk); #1;
    vc_wr_en = 1'b1; vc_wr_idx = VW'(v); vc_wr_mask = m;
    @(posedge clk); #1;
    vc_wr_en = 1'b0;
  endtask

  task automatic req(input int v);
    @(posedge clk); #1;
    req_valid = 1'b1; req_idx = VW'(v);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int pend_exp;
    int intx0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 / R2 reset state and readout
    chk("R1 ctl_word", int'(ctl_word), NV - 1);
    chk("R2 table size", int'(ctl_word[10:0]), NV - 1);
    chk("R1 vec_mask", int'(vec_mask), (1 << NV) - 1);
    chk("R1 vec_pend", int'(vec_pend), 0);
    chk("R1 msg_valid", int'(msg_valid), 0);
    chk("R1 sweep_busy", int'(sweep_busy), 0);

    // R6 requests ignored while disabled
    msg_cnt = 0;
    for (int v = 0; v < NV; v++) req(v);
    idle(5);
    chk("R6 pend disabled", int'(vec_pend), 0);
    chk("R6 msg disabled", msg_cnt, 0);

    // R8 / R9 enable write: strobe and sweep length
    intx0 = intx_cnt; busy_cnt = 0;
    ctl_wr(8'h80);
    idle(NV + 4);
    chk("R8 intx on enable", intx_cnt - intx0, 1);
    chk("R9 busy cycles", busy_cnt, NV);
    chk("R2 ctl enable", int'(ctl_word), 32768 + NV - 1);

    // R4 masked requests park
    msg_cnt = 0;
    for (int v = 0; v < NV; v++) begin
      req(v);
      idle(4);
      chk("R4 pend build", int'(vec_pend), (1 << (v + 1)) - 1);
    end
    chk("R4 no msg masked", msg_cnt, 0);

    // R7 unmask each pending vector
    for (int v = 0; v < NV; v++) begin
      msg_cnt = 0;
      vc_wr(v, 1'b0);
      idle(6);
      chk("R7 one msg", msg_cnt, 1);
      chk("R7 msg idx", msg_log[0], v);
      chk("R7 pend cleared", int'(vec_pend), ((1 << NV) - 1) & ~((1 << (v + 1)) - 1));
    end
    chk("R3 all unmasked", int'(vec_mask), 0);

    // R5 direct delivery
    for (int v = 0; v < NV; v++) begin
      msg_cnt = 0;
      req(v);
      idle(5);
      chk("R5 one msg", msg_cnt, 1);
      chk("R5 msg idx", msg_log[0], v);
      chk("R5 pend clear", int'(vec_pend), 0);
    end

    // R3 function mask overrides cleared vector masks
    intx0 = intx_cnt; msg_cnt = 0;
    ctl_wr(8'hC0);
    idle(3);
    chk("R8 intx fmask write", intx_cnt - intx0, 1);
    req(1); req(3); req(6);
    idle(4);
    chk("R3 fmask parks", int'(vec_pend), 8'h4A);
    vc_wr(3, 1'b0);
    idle(4);
    chk("R3 fmask overrides", int'(vec_pend), 8'h4A);
    chk("R3 no msg fmask", msg_cnt, 0);

    // R9 clearing function mask sweeps ascending
    busy_cnt = 0; msg_cnt = 0;
    ctl_wr(8'h80);
    idle(NV + 6);
    chk("R9 sweep count", msg_cnt, 3);
    chk("R9 order 0", msg_log[0], 1);
    chk("R9 order 1", msg_log[1], 3);
    chk("R9 order 2", msg_log[2], 6);
    chk("R9 pend cleared", int'(vec_pend), 0);
    chk("R9 busy cycles", busy_cnt, NV);

    // R3 mask readout
    for (int v = 0; v < NV; v += 2) vc_wr(v, 1'b1);
    idle(2);
    chk("R3 mask readout", int'(vec_mask), 8'h55);

    // R10 back-pressure
    msg_ready = 1'b0; msg_cnt = 0;
    req(7); req(5);
    idle(4);
    chk("R10 valid held", int'(msg_valid), 1);
    chk("R10 idx held", int'(msg_idx), 7);
    idle(3);
    chk("R10 idx stable", int'(msg_idx), 7);
    msg_ready = 1'b1;
    idle(5);
    chk("R10 drained", msg_cnt, 2);
    chk("R10 first", msg_log[0], 7);
    chk("R10 second", msg_log[1], 5);

    // R6 / R8 disable write
    req(2);
    idle(4);
    pend_exp = int'(vec_pend);
    chk("R4 even masked park", pend_exp, 4);
    intx0 = intx_cnt; msg_cnt = 0;
    ctl_wr(8'h00);
    idle(3);
    chk("R8 no intx disabled", intx_cnt - intx0, 0);
    req(1); req(4);
    idle(4);
    chk("R6 pend unchanged", int'(vec_pend), pend_exp);
    chk("R6 no msg", msg_cnt, 0);
    chk("R2 ctl disabled", int'(ctl_word), NV - 1);

    // R2 reserved bits of the byte ignored
    ctl_wr(8'hFF);
    idle(2);
    chk("R2 reserved ignored", int'(ctl_word), 49152 + NV - 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule